// File: doc/BRIEF.md
# Memory-Mapped I/O Bus Bridge

This bridge sits behind a small processor's local bus and sorts each word access by address. Accesses whose top two address bits are both one are handed to an external I/O bus. The bridge registers the address, the read or write strobe, the byte enables and the write data, and keeps them steady until the far side answers with a ready pulse. It then gives the processor a one-cycle ready, together with the captured read data. A small low window raises a combinational select toward the internal peripheral registers, which answer the processor themselves. The reserved gap between that window and the I/O window is closed off by the bridge with a zero-data response.

The processor request side has no stall signal. A requester presents one access and waits for its ready before it presents the next. Any strobe that arrives while an I/O transfer is outstanding is dropped and is not queued. The I/O side is a request/ready pair: the bridge holds its request until ready, and the external side may stretch the transfer for as long as it needs.

Top module: `iobr_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, every register clears. From the cycle after the first reset edge, the outputs io_as, io_rd, io_wr, cpu_ready and cpu_rdata are all zero.
- R2: An access is only taken when cpu_as is high and exactly one of cpu_rd and cpu_wr is high. A cpu_as with both strobes high, or with neither, has no effect.
- R3: An idle access with address 0xC0000000 to 0xFFFFFFFF (cpu_addr[31:30] = 2'b11) starts an I/O transfer from the next cycle. io_as goes high, io_rd or io_wr goes high to match the access type, and io_addr, io_be and io_wdata carry the full address, byte enables and write data.
- R4: While io_as is high and io_ready has not been sampled high, the I/O outputs io_as, io_rd, io_wr, io_addr, io_be and io_wdata stay unchanged.
- R5: When io_ready is sampled high while a transfer is outstanding, the following cycle shows three things: io_as, io_rd and io_wr are low, cpu_ready is high for exactly that one cycle, and cpu_rdata equals the sampled io_rdata for a read, or zero for a write.
- R6: io_ready has no effect when no transfer is outstanding, and cpu_ready stays low.
- R7: While a transfer is outstanding, no new access is accepted. periph_sel stays low, and an I/O-window access neither changes io_addr nor starts a later transfer.
- R8: An idle access to 0x80000000 to 0x800000FF drives periph_sel high in the same cycle. It raises no I/O strobe and no cpu_ready from the bridge.
- R9: An idle access to 0x80000100 to 0xBFFFFFFF drives cpu_ready high for one cycle in the next cycle with cpu_rdata zero. It raises no I/O strobe and no periph_sel.
- R10: An access below 0x80000000 produces no I/O strobe, no periph_sel and no cpu_ready.
- R11: cpu_rdata keeps its last completion value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_as | input | 1 | Processor address strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 32 | Processor byte address |
| cpu_be | input | 4 | Processor byte enables |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | One-cycle completion to the processor |
| cpu_rdata | output | 32 | Read data returned to the processor |
| io_as | output | 1 | I/O bus request, held until ready |
| io_rd | output | 1 | I/O bus read strobe |
| io_wr | output | 1 | I/O bus write strobe |
| io_addr | output | 32 | I/O bus address |
| io_be | output | 4 | I/O bus byte enables |
| io_wdata | output | 32 | I/O bus write data |
| io_rdata | input | 32 | I/O bus read data |
| io_ready | input | 1 | I/O bus ready handshake |
| periph_sel | output | 1 | Select for internal peripheral registers |

## Verification
The bench drives the window edges at 0x7FFFFFFC, 0x800000FF, 0x80000100, 0xBFFFFFFF and 0xC0000000. A decoder with an off-by-one boundary would select the wrong target there, or answer an access that is not its own. The bench also holds io_ready low for several cycles while new accesses arrive. A bridge that accepted them would corrupt io_addr or raise periph_sel, and one that let the held request drift would change an I/O output before ready. Further checks cover strobe pairs that are not legal, io_ready pulses with nothing outstanding, writes answered with non-zero read data, and back-to-back reserved accesses. Those catch a bridge that accepted an unqualified strobe, answered a stray ready, leaked read data into write or reserved completions, or failed to hold cpu_rdata between completions.

// File: rtl/iobr_pkg.sv
package iobr_pkg;
  // Target chosen by the address decoder
  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_IO     = 2'd1,
    RGN_PERIPH = 2'd2,
    RGN_RSV    = 2'd3
  } region_e;
endpackage

// File: rtl/iobr_decode.sv
module iobr_decode
  import iobr_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] IO_BASE  = 32'hC000_0000,
  parameter logic [AW-1:0] IO_MASK  = 32'hC000_0000,
  parameter logic [AW-1:0] PER_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] PER_MASK = 32'hFFFF_FF00,
  parameter logic [AW-1:0] RSV_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] RSV_MASK = 32'hC000_0000
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  // Priority: I/O window, then peripheral window, then the reserved span
  // that encloses the peripheral window.
  always_comb begin
    if ((addr & IO_MASK) == IO_BASE)        region = RGN_IO;
    else if ((addr & PER_MASK) == PER_BASE) region = RGN_PERIPH;
    else if ((addr & RSV_MASK) == RSV_BASE) region = RGN_RSV;
    else                                    region = RGN_NONE;
  end
endmodule

// File: rtl/iobr_req_hold.sv
module iobr_req_hold #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           start_wr,
  input  logic [AW-1:0]  addr,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  wdata,
  input  logic           io_ready,
  output logic           io_as,
  output logic           io_rd,
  output logic           io_wr,
  output logic [AW-1:0]  io_addr,
  output logic [BEW-1:0] io_be,
  output logic [DW-1:0]  io_wdata,
  output logic           done,
  output logic           done_rd
);
  localparam int LANE = DW / BEW;

  logic busy_q;

  assign io_as   = busy_q;
  assign done    = busy_q & io_ready;
  assign done_rd = io_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      io_rd   <= 1'b0;
      io_wr   <= 1'b0;
      io_addr <= '0;
      io_be   <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      io_rd  <= 1'b0;
      io_wr  <= 1'b0;
    end else if (start) begin
      busy_q  <= 1'b1;
      io_rd   <= ~start_wr;
      io_wr   <= start_wr;
      io_addr <= addr;
      io_be   <= be;
    end
  end

  // Write data held per byte lane
  for (genvar g = 0; g < BEW; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        io_wdata[g*LANE +: LANE] <= '0;
      else if (start && !busy_q)
        io_wdata[g*LANE +: LANE] <= wdata[g*LANE +: LANE];
    end
  end
endmodule

// File: rtl/iobr_complete.sv
module iobr_complete #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_done,
  input  logic          io_done_rd,
  input  logic [DW-1:0] io_rdata,
  input  logic          rsv_done,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= io_done | rsv_done;
      if (io_done)
        cpu_rdata <= io_done_rd ? io_rdata : '0;
      else if (rsv_done)
        cpu_rdata <= '0;
    end
  end
endmodule

// File: rtl/iobr_top.sv
module iobr_top
  import iobr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PER_ADDR_BITS = 8,
  parameter logic [AW-1:0] IO_BASE  = 32'hC000_0000,
  parameter logic [AW-1:0] IO_MASK  = 32'hC000_0000,
  parameter logic [AW-1:0] PER_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] RSV_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] RSV_MASK = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_as,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW/8-1:0]   cpu_be,
  input  logic [DW-1:0]     cpu_wdata,
  output logic              cpu_ready,
  output logic [DW-1:0]     cpu_rdata,
  output logic              io_as,
  output logic              io_rd,
  output logic              io_wr,
  output logic [AW-1:0]     io_addr,
  output logic [DW/8-1:0]   io_be,
  output logic [DW-1:0]     io_wdata,
  input  logic [DW-1:0]     io_rdata,
  input  logic              io_ready,
  output logic              periph_sel
);
  localparam int BEW = DW / 8;
  localparam logic [AW-1:0] PER_MASK = ~((AW'(1) << PER_ADDR_BITS) - AW'(1));

  region_e region;
  logic    acc_ok, idle, start_io, start_rsv, io_done, io_done_rd;

  iobr_decode #(
    .AW(AW), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK),
    .PER_BASE(PER_BASE), .PER_MASK(PER_MASK),
    .RSV_BASE(RSV_BASE), .RSV_MASK(RSV_MASK)
  ) i_decode (
    .addr   (cpu_addr),
    .region (region)
  );

  assign acc_ok     = cpu_as & (cpu_rd ^ cpu_wr);
  assign idle       = ~io_as;
  assign start_io   = acc_ok & idle & (region == RGN_IO);
  assign start_rsv  = acc_ok & idle & (region == RGN_RSV);
  assign periph_sel = acc_ok & idle & (region == RGN_PERIPH);

  iobr_req_hold #(.AW(AW), .DW(DW), .BEW(BEW)) i_hold (
    .clk      (clk),
    .rst      (rst),
    .start    (start_io),
    .start_wr (cpu_wr),
    .addr     (cpu_addr),
    .be       (cpu_be),
    .wdata    (cpu_wdata),
    .io_ready (io_ready),
    .io_as    (io_as),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_be    (io_be),
    .io_wdata (io_wdata),
    .done     (io_done),
    .done_rd  (io_done_rd)
  );

  iobr_complete #(.DW(DW)) i_complete (
    .clk        (clk),
    .rst        (rst),
    .io_done    (io_done),
    .io_done_rd (io_done_rd),
    .io_rdata   (io_rdata),
    .rsv_done   (start_rsv),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata)
  );
endmodule

// File: rtl/iobr_checker.sv
module iobr_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] IO_BASE  = 32'hC000_0000,
  parameter logic [AW-1:0] IO_MASK  = 32'hC000_0000,
  parameter logic [AW-1:0] RSV_BASE = 32'h8000_0000,
  parameter logic [AW-1:0] RSV_MASK = 32'hC000_0000,
  parameter int PER_ADDR_BITS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_as,
  input logic            cpu_rd,
  input logic            cpu_wr,
  input logic [AW-1:0]   cpu_addr,
  input logic            cpu_ready,
  input logic [DW-1:0]   cpu_rdata,
  input logic            io_as,
  input logic            io_rd,
  input logic            io_wr,
  input logic [AW-1:0]   io_addr,
  input logic [DW/8-1:0] io_be,
  input logic [DW-1:0]   io_wdata,
  input logic [DW-1:0]   io_rdata,
  input logic            io_ready,
  input logic            periph_sel
);
  logic rsv_hit;
  assign rsv_hit = ((cpu_addr & RSV_MASK) == RSV_BASE) &&
                   ((cpu_addr >> PER_ADDR_BITS) != (RSV_BASE >> PER_ADDR_BITS));

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!io_as && !cpu_ready && cpu_rdata == '0));

  a_r3_strobe_kind: assert property (@(posedge clk) disable iff (rst)
    io_as |-> (io_rd != io_wr));

  a_r3_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    !io_as |-> (!io_rd && !io_wr));

  a_r3_in_window: assert property (@(posedge clk) disable iff (rst)
    io_as |-> ((io_addr & IO_MASK) == IO_BASE));

  a_r4_io_hold: assert property (@(posedge clk) disable iff (rst)
    (io_as && !io_ready) |=> (io_as && $stable(io_addr) && $stable(io_be) &&
                              $stable(io_wdata) && $stable(io_rd) && $stable(io_wr)));

  a_r5_complete: assert property (@(posedge clk) disable iff (rst)
    (io_as && io_ready) |=> (cpu_ready && !io_as));

  a_r5_read_data: assert property (@(posedge clk) disable iff (rst)
    (io_as && io_rd && io_ready) |=> (cpu_rdata == $past(io_rdata)));

  a_r5_write_zero: assert property (@(posedge clk) disable iff (rst)
    (io_as && io_wr && io_ready) |=> (cpu_rdata == '0));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!io_as && !cpu_as) |=> !cpu_ready);

  a_r7_no_sel_busy: assert property (@(posedge clk) disable iff (rst)
    io_as |-> !periph_sel);

  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (cpu_as && (cpu_rd != cpu_wr) && !io_as && rsv_hit) |=>
      (cpu_ready && cpu_rdata == '0 && !io_as));
endmodule

bind iobr_top iobr_checker #(
  .AW(AW), .DW(DW), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK),
  .RSV_BASE(RSV_BASE), .RSV_MASK(RSV_MASK), .PER_ADDR_BITS(PER_ADDR_BITS)
) i_chk (
  .clk(clk), .rst(rst), .cpu_as(cpu_as), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
  .io_as(io_as), .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr),
  .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .io_ready(io_ready), .periph_sel(periph_sel)
);

// File: tb/test_iobr_top.sv
module test_iobr_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_as, cpu_rd, cpu_wr;
  logic [31:0] cpu_addr, cpu_wdata, io_rdata;
  logic [3:0]  cpu_be;
  logic        io_ready;
  logic        cpu_ready, io_as, io_rd, io_wr, periph_sel;
  logic [31:0] cpu_rdata, io_addr, io_wdata;
  logic [3:0]  io_be;

  always #2 clk = ~clk;

  iobr_top i_iobr_top (
    .clk(clk), .rst(rst), .cpu_as(cpu_as), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .io_as(io_as),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
    .periph_sel(periph_sel)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural reference state
  bit          m_busy, m_rd, m_wr, m_ready;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_be;

  function automatic bit legal();
    return cpu_as && (cpu_rd != cpu_wr);
  endfunction

  always @(posedge clk) begin
    bit          nready;
    logic [31:0] nrdata;
    if (rst) begin
      m_busy = 0; m_rd = 0; m_wr = 0; m_ready = 0;
      m_addr = 0; m_wdata = 0; m_rdata = 0; m_be = 0;
    end else begin
      nready = 0;
      nrdata = m_rdata;
      if (m_busy) begin
        if (io_ready) begin
          nready = 1;
          nrdata = m_rd ? io_rdata : 32'h0;
          m_busy = 0; m_rd = 0; m_wr = 0;
        end
      end else if (legal()) begin
        if (cpu_addr >= 32'hC000_0000) begin
          m_busy = 1; m_rd = cpu_rd; m_wr = cpu_wr;
          m_addr = cpu_addr; m_be = cpu_be; m_wdata = cpu_wdata;
        end else if (cpu_addr >= 32'h8000_0100) begin
          nready = 1;
          nrdata = 32'h0;
        end
      end
      m_ready = nready;
      m_rdata = nrdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit m_sel;
    m_sel = legal() && !m_busy && cpu_addr >= 32'h8000_0000 && cpu_addr <= 32'h8000_00FF;
    check("R5 cpu_ready", 32'(cpu_ready), 32'(m_ready));
    check("R11 cpu_rdata", cpu_rdata, m_rdata);
    check("R4 io_as", 32'(io_as), 32'(m_busy));
    check("R4 io_rd", 32'(io_rd), 32'(m_rd));
    check("R4 io_wr", 32'(io_wr), 32'(m_wr));
    check("R3 io_addr", io_addr, m_addr);
    check("R3 io_be", 32'(io_be), 32'(m_be));
    check("R3 io_wdata", io_wdata, m_wdata);
    check("R8 periph_sel", 32'(periph_sel), 32'(m_sel));
  endtask

  task automatic step(input bit as, input bit rd, input bit wr, input logic [31:0] a,
                      input logic [3:0] be, input logic [31:0] wd,
                      input bit rdy, input logic [31:0] rdat);
    cpu_as = as; cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_be = be;
    cpu_wdata = wd; io_ready = rdy; io_rdata = rdat;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 32'h0, 4'h0, 32'h0, 0, 32'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] ra;
    rst = 1;
    idle(3);
    // R1 reset state
    check("R1 io_as", 32'(io_as), 0);
    check("R1 cpu_ready", 32'(cpu_ready), 0);
    check("R1 cpu_rdata", cpu_rdata, 0);
    rst = 0;
    idle(2);

    // R2 unqualified strobes ignored
    step(1, 1, 1, 32'hC000_0010, 4'hF, 32'h1111_1111, 0, 0);
    check("R2 both strobes io_as", 32'(io_as), 0);
    step(1, 0, 0, 32'h8000_0200, 4'hF, 32'h0, 0, 0);
    check("R2 no strobe cpu_ready", 32'(cpu_ready), 0);
    idle(1);

    // R6 stray ready
    step(0, 0, 0, 32'h0, 4'h0, 32'h0, 1, 32'hDEAD_BEEF);
    check("R6 stray ready", 32'(cpu_ready), 0);

    // R3 R4 R7 R5 I/O read
    step(1, 1, 0, 32'hC000_1234, 4'hF, 32'h0, 0, 0);
    check("R3 read start io_as", 32'(io_as), 1);
    check("R3 read start io_addr", io_addr, 32'hC000_1234);
    step(1, 0, 1, 32'hFFFF_0000, 4'h3, 32'hAAAA_5555, 0, 0);
    check("R7 dropped io access", io_addr, 32'hC000_1234);
    step(1, 1, 0, 32'h8000_0004, 4'hF, 32'h0, 0, 0);
    check("R7 periph_sel while busy", 32'(periph_sel), 0);
    idle(2);
    check("R4 still held", 32'(io_rd), 1);
    step(0, 0, 0, 32'h0, 4'h0, 32'h0, 1, 32'hCAFE_F00D);
    check("R5 read ready", 32'(cpu_ready), 1);
    check("R5 read data", cpu_rdata, 32'hCAFE_F00D);
    idle(1);
    check("R5 single pulse", 32'(cpu_ready), 0);
    check("R11 data held", cpu_rdata, 32'hCAFE_F00D);
    check("R7 no late start", 32'(io_as), 0);

    // R5 write: lowest I/O address, non-zero read data on ready
    step(1, 0, 1, 32'hC000_0000, 4'b0011, 32'h1234_5678, 0, 0);
    check("R3 write io_wdata", io_wdata, 32'h1234_5678);
    check("R3 write io_be", 32'(io_be), 32'h3);
    idle(3);
    step(0, 0, 0, 32'h0, 4'h0, 32'h0, 1, 32'h9999_9999);
    check("R5 write data zero", cpu_rdata, 0);

    // R8 peripheral top edge
    step(1, 1, 0, 32'h8000_00FF, 4'hF, 32'h0, 0, 0);
    check("R8 periph_sel", 32'(periph_sel), 1);
    check("R8 no io", 32'(io_as), 0);
    idle(1);
    check("R8 no cpu_ready", 32'(cpu_ready), 0);

    // R9 reserved edges, back to back
    step(1, 1, 0, 32'h8000_0100, 4'hF, 32'h0, 0, 0);
    check("R9 low edge ready", 32'(cpu_ready), 1);
    check("R9 low edge data", cpu_rdata, 0);
    step(1, 0, 1, 32'hBFFF_FFFF, 4'hF, 32'h5, 0, 0);
    check("R9 high edge ready", 32'(cpu_ready), 1);
    check("R9 no io", 32'(io_as), 0);
    idle(1);

    // R10 below the decoded space
    step(1, 1, 0, 32'h7FFF_FFFC, 4'hF, 32'h0, 0, 0);
    check("R10 no periph_sel", 32'(periph_sel), 0);
    idle(1);
    check("R10 no ready", 32'(cpu_ready), 0);
    check("R10 no io", 32'(io_as), 0);

    // Mixed traffic against the model
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[4:2])
        3'd0, 3'd1: ra = {2'b11, lfsr[31:2]};
        3'd2:       ra = {24'h80_0000, lfsr[15:8]};
        3'd3:       ra = {2'b10, lfsr[31:2]};
        3'd4:       ra = {1'b0, lfsr[31:1]};
        3'd5:       ra = 32'hBFFF_FFFF;
        3'd6:       ra = 32'h8000_00FF;
        default:    ra = 32'hFFFF_FFFF;
      endcase
      step(lfsr[5], lfsr[6], lfsr[7] | ~lfsr[6], ra, lfsr[11:8], {lfsr[15:0], lfsr[31:16]},
           lfsr[12] & lfsr[13], lfsr ^ 32'h5A5A_5A5A);
    end
    idle(4);

    finished = 1;
    summary();
    $finish;
  end
endmodule